// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block is a bank of glitch filters for asynchronous digital input terminals. Each channel brings its raw terminal into the filter clock domain through a synchronizer. It then moves its filtered output to a new level only once that level has been seen on a set number of back-to-back filter-clock samples. Shorter excursions are dropped. The filter clock is nominally 40 MHz, so one sample is 25 ns.

Each channel holds its own setting:
- **Off:** the output follows the synchronized input.
- **Short:** 5 samples.
- **Medium:** 257 samples.
- **Long:** a run of prescaler ticks, where one tick is every 400 clocks and 255 ticks make roughly 2.55 ms. The long count therefore moves with a coarse timebase and has up to one tick of jitter.

The filter acts the same way on rising and falling edges. Every channel also drives a bypass output that carries the synchronized but unfiltered level. Direct terminal-to-terminal routes take that bypass output.

Setting codes arrive on a shared code bus, with a per-channel write strobe.

Top module: `gf_filter_bank`

## Requirements
- R1: After reset every channel is in the off setting (code 2'b00), and all filtered and bypass outputs are low.
- R2: In the off setting the filtered output equals the input three clock edges after the input changes. The first two edges are the synchronizer and the third is the output register. Pulses of any width are reproduced with their width unchanged.
- R3: In the short setting (code 2'b01) the output takes a new level on the 5th consecutive sample of that level. That is 7 edges after the input change. A 5-sample pulse passes with its width kept, and a 4-sample pulse is rejected.
- R4: In the medium setting (code 2'b10) a 257-sample pulse passes with its width kept, and a 256-sample pulse is rejected.
- R5: In the long setting (code 2'b11) only samples that coincide with a prescaler tick (one every LONG_DIV clocks) advance the count, and LONG_TICKS such samples are needed. A pulse of LONG_TICKS*LONG_DIV clocks always passes, and one of (LONG_TICKS-1)*LONG_DIV clocks is always rejected.
- R6: The filter is symmetric. Starting from a high output, a low pulse shorter than the threshold is rejected and one at the threshold passes.
- R7: Any sample that matches the current output restarts the consecutive-sample count. In the short setting, 4 high, 1 low and then 4 high samples never raise the output.
- R8: Writing a setting affects only the channels whose bit in cfg_we_i is set. The other channels keep their setting and behaviour.
- R9: A setting write clears that channel's count and leaves its filtered output unchanged. A full threshold of new samples is needed after the write.
- R10: bypass_o carries the synchronized unfiltered input, two edges after the terminal, whatever the channel's setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | NUM_CH | Raw asynchronous terminal levels |
| cfg_we_i | input | NUM_CH | Per-channel setting write strobe |
| cfg_mode_i | input | 2 | Setting code to write: 00 off, 01 short, 10 medium, 11 long |
| filt_o | output | NUM_CH | Filtered levels |
| bypass_o | output | NUM_CH | Synchronized unfiltered levels for direct routes |

## Verification
Several properties are checked on every cycle:
- A filtered output only ever moves to the level of the previous sample.
- A setting write freezes the output for that cycle.
- The count never passes the active threshold and stays cleared while the channel is off.
- Prescaler ticks are never adjacent.

The pass/reject boundaries of each setting need the directed scenarios, since they depend on a whole run of samples. So do the exact latencies, preserved pulse widths, the restart on a mismatching sample, channel independence and the full threshold needed after a rewrite.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic [1:0] {
    GF_OFF   = 2'b00,
    GF_SHORT = 2'b01,
    GF_MED   = 2'b10,
    GF_LONG  = 2'b11
  } gf_mode_e;
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gf_prescaler.sv
module gf_prescaler #(
  parameter int unsigned DIV = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + PW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // R5
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/gf_channel.sv
module gf_channel
  import gf_pkg::*;
#(
  parameter int unsigned SHORT_N    = 5,
  parameter int unsigned MED_N      = 257,
  parameter int unsigned LONG_TICKS = 255,
  parameter int unsigned CW         = 9
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sample_i,
  input  logic     tick_i,
  input  logic     cfg_we_i,
  input  gf_mode_e cfg_mode_i,
  output logic     filt_o
);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_N - 1);
  localparam logic [CW-1:0] MED_LIM   = CW'(MED_N - 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_TICKS - 1);

  gf_mode_e      mode_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic [CW-1:0] limit;
  logic          step;

  always_comb begin
    limit = '0;
    step  = 1'b1;
    unique case (mode_q)
      GF_SHORT: limit = SHORT_LIM;
      GF_MED:   limit = MED_LIM;
      GF_LONG: begin
        limit = LONG_LIM;
        step  = tick_i;
      end
      default: limit = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= GF_OFF;
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (cfg_we_i) begin
      // new setting restarts the run, level held
      mode_q <= cfg_mode_i;
      cnt_q  <= '0;
    end else if (mode_q == GF_OFF) begin
      filt_q <= sample_i;
      cnt_q  <= '0;
    end else if (sample_i == filt_q) begin
      cnt_q <= '0;
    end else if (step) begin
      if (cnt_q == limit) begin
        filt_q <= sample_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign filt_o = filt_q;

  // R3 R4 R5
  agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> ($past(sample_i) == filt_o));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> $stable(filt_o));

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != GF_OFF) |-> (cnt_q <= limit));

  // R2
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == GF_OFF) |=> (cnt_q == '0));
endmodule

// File: rtl/gf_filter_bank.sv
module gf_filter_bank
  import gf_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SHORT_N     = 5,
  parameter int unsigned MED_N       = 257,
  parameter int unsigned LONG_DIV    = 400,
  parameter int unsigned LONG_TICKS  = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] din_i,
  input  logic [NUM_CH-1:0] cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  output logic [NUM_CH-1:0] filt_o,
  output logic [NUM_CH-1:0] bypass_o
);
  localparam int unsigned MAX_SM = (SHORT_N > MED_N) ? SHORT_N : MED_N;
  localparam int unsigned MAX_N  = (MAX_SM > LONG_TICKS) ? MAX_SM : LONG_TICKS;
  localparam int unsigned CW     = (MAX_N > 2) ? $clog2(MAX_N) : 1;

  logic [NUM_CH-1:0] sample;
  logic              tick;
  gf_mode_e          cfg_mode;

  assign cfg_mode = gf_mode_e'(cfg_mode_i);

  gf_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (sample)
  );

  gf_prescaler #(.DIV(LONG_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gf_channel #(
      .SHORT_N   (SHORT_N),
      .MED_N     (MED_N),
      .LONG_TICKS(LONG_TICKS),
      .CW        (CW)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sample_i  (sample[c]),
      .tick_i    (tick),
      .cfg_we_i  (cfg_we_i[c]),
      .cfg_mode_i(cfg_mode),
      .filt_o    (filt_o[c])
    );
  end

  assign bypass_o = sample;
endmodule

// File: tb/tb_gf_filter_bank.sv
module tb_gf_filter_bank;
  localparam int NCH   = 4;
  localparam int DIV   = 8;
  localparam int TICKS = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] din = '0;
  logic [NCH-1:0] we = '0;
  logic [1:0]     mode = 2'b00;
  logic [NCH-1:0] filt;
  logic [NCH-1:0] byp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gf_filter_bank #(
    .NUM_CH(NCH), .LONG_DIV(DIV), .LONG_TICKS(TICKS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .cfg_we_i(we),
    .cfg_mode_i(mode), .filt_o(filt), .bypass_o(byp)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    we[ch] = 1'b1;
    mode   = m;
    @(negedge clk);
    we[ch] = 1'b0;
  endtask

  // drives a pulse of 'width' cycles away from 'base', counts deviating cycles and first-change delay
  task automatic pulse(input int ch, input logic base, input int width, input int window,
                       output int hi, output int delay);
    hi = 0;
    delay = -1;
    din[ch] = ~base;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (filt[ch] != base) begin
        hi++;
        if (delay < 0) delay = i + 1;
      end
      if (i + 1 == width) din[ch] = base;
    end
  endtask

  task automatic t_reset();
    check("R1 filt after reset", int'(filt), 0);
    check("R1 bypass after reset", int'(byp), 0);
  endtask

  task automatic t_off();
    int hi, dl;
    pulse(0, 1'b0, 3, 20, hi, dl);
    check("R2 off width", hi, 3);
    check("R2 off delay", dl, 3);
  endtask

  task automatic t_short();
    int hi, dl;
    set_mode(0, 2'b01);
    pulse(0, 1'b0, 5, 30, hi, dl);
    check("R3 short 5 passes width", hi, 5);
    check("R3 short delay", dl, 7);
    pulse(0, 1'b0, 4, 30, hi, dl);
    check("R3 short 4 rejected", hi, 0);
  endtask

  task automatic t_medium();
    int hi, dl;
    set_mode(1, 2'b10);
    pulse(1, 1'b0, 257, 540, hi, dl);
    check("R4 medium 257 passes", hi, 257);
    pulse(1, 1'b0, 256, 540, hi, dl);
    check("R4 medium 256 rejected", hi, 0);
  endtask

  task automatic t_long();
    int hi, dl;
    set_mode(2, 2'b11);
    pulse(2, 1'b0, TICKS * DIV, 2 * TICKS * DIV + 4 * DIV, hi, dl);
    check("R5 long pass", int'(hi > 0), 1);
    pulse(2, 1'b0, (TICKS - 1) * DIV, 2 * TICKS * DIV + 4 * DIV, hi, dl);
    check("R5 long reject", hi, 0);
  endtask

  task automatic t_symmetric();
    int hi, dl;
    din[0] = 1'b1;
    wait_n(12);
    check("R6 settled high", int'(filt[0]), 1);
    pulse(0, 1'b1, 4, 30, hi, dl);
    check("R6 low 4 rejected", hi, 0);
    pulse(0, 1'b1, 5, 30, hi, dl);
    check("R6 low 5 passes", hi, 5);
    din[0] = 1'b0;
    wait_n(12);
    check("R6 settled low", int'(filt[0]), 0);
  endtask

  task automatic t_restart();
    int hi = 0;
    for (int i = 0; i < 30; i++) begin
      din[0] = (i < 9 && i != 4) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (filt[0]) hi++;
    end
    check("R7 broken run rejected", hi, 0);
  endtask

  task automatic t_indep();
    din[3] = 1'b1;
    din[0] = 1'b1;
    wait_n(3);
    check("R8 off channel follows", int'(filt[3]), 1);
    check("R8 short channel waits", int'(filt[0]), 0);
    wait_n(4);
    check("R8 short channel rises", int'(filt[0]), 1);
    din[3] = 1'b0;
    din[0] = 1'b0;
    wait_n(12);
  endtask

  task automatic t_rewrite();
    din[1] = 1'b1;
    wait_n(200);
    set_mode(1, 2'b10);
    check("R9 output held at write", int'(filt[1]), 0);
    wait_n(256);
    check("R9 not yet after 256", int'(filt[1]), 0);
    wait_n(1);
    check("R9 rises after 257", int'(filt[1]), 1);
    din[1] = 1'b0;
    wait_n(270);
  endtask

  task automatic t_bypass();
    din[0] = 1'b1;
    wait_n(1);
    check("R10 bypass not yet", int'(byp[0]), 0);
    wait_n(1);
    check("R10 bypass after 2", int'(byp[0]), 1);
    din[0] = 1'b0;
    wait_n(1);
    check("R10 filt stays low", int'(filt[0]), 0);
    wait_n(1);
    check("R10 bypass falls", int'(byp[0]), 0);
    check("R10 filt rejects", int'(filt[0]), 0);
    wait_n(10);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_off();
    t_short();
    t_medium();
    t_long();
    t_symmetric();
    t_restart();
    t_indep();
    t_rewrite();
    t_bypass();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule